// File: doc/BRIEF.md
# Time-Shared Cascaded Biquad Filter

This block is a recursive fixed-point filter that behaves as a chain of up to 25 second-order sections. Only one section's worth of arithmetic exists in hardware. A section index steps through the chain once for every accepted sample. Each step reads that section's coefficients and its two delay values, computes the section output, writes the updated delays back, and returns the result through an internal feedback register so that it becomes the input of the next section. The response of the last section is the filter output.

The host writes the four coefficients of each section into a small register bank before it streams samples. Samples enter through a ready/valid handshake and leave as a one-cycle valid pulse. A clear input empties every section's delay memory between measurements. The sweep zeroes one section per cycle. Coefficients survive a clear.

The controller has three states:
- `ST_IDLE`: waiting for a sample.
- `ST_RUN`: stepping through the sections.
- `ST_CLEAR`: zeroing the delay memory.

Its transitions are:
- IDLE→RUN on an accepted sample.
- RUN→IDLE after the last section.
- IDLE→CLEAR or RUN→CLEAR whenever `clr` is high.
- CLEAR→IDLE after the last entry is zeroed, if `clr` is then low.
- CLEAR→CLEAR, restarting the sweep, if `clr` is still high at the last entry.

Top module: `iir_cascade_tm`

## Requirements
- R1: While reset is low and in the first cycle after it, `in_ready`=1, `busy`=0, `out_valid`=0 and `out_data`=0. Reset also zeroes all coefficients and all delay values, so a fresh filter passes samples through unchanged.
- R2: A write with `cfg_we`=1 stores `cfg_data` into section `cfg_sec` (0..NSEC-1). `cfg_sel` picks the field: 0=a2, 1=a3, 2=b2, 3=b3. Coefficients are signed 16-bit with 14 fraction bits (16384 = 1.0).
- R3: Each section computes y = x + w1. The new delays are w1' = ⌊b2·x/2^14⌋ − ⌊a2·y/2^14⌋ + w2 and w2' = ⌊b3·x/2^14⌋ − ⌊a3·y/2^14⌋. Every product is shifted by itself, toward minus infinity, and all sums wrap at 32 bits.
- R4: Section 0 takes the input sample. The output y of section k is the input x of section k+1. The filter output is the y of section NSEC-1.
- R5: A sample is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `out_valid` is high for exactly one cycle, NSEC edges after the accepting edge. `out_data` holds its value until the next result.
- R6: `in_ready` is 1 only while the controller is idle and `clr` is low. `in_valid` at any other time is ignored.
- R7: A sample enters the datapath as in_data·2^12. The output is ⌊y/2^12⌋, saturated to the range −32768..32767.
- R8: `clr`=1 at an edge in any state enters the clear sweep. The sweep keeps `busy`=1 for NSEC cycles and restarts while `clr` stays high. A sample being processed when `clr` arrives is dropped and produces no `out_valid`.
- R9: After a clear, every delay value is zero and the coefficients are unchanged. The next sample gets the response of a freshly started filter.
- R10: Each section's delay values persist from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Empty all delay memories |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DW (16) | Signed input sample |
| in_ready | output | 1 | Sample can be accepted |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW (16) | Signed filter output |
| busy | output | 1 | Running through sections or clearing |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sec | input | SW (2) | Section index of the write |
| cfg_sel | input | 2 | Coefficient field: 0=a2 1=a3 2=b2 3=b3 |
| cfg_data | input | CW (16) | Signed Q2.14 coefficient |

## Verification
The assertions check the following properties on every cycle:
- the result strobe lasts one cycle and only ever closes a busy period;
- the output value stays fixed between strobes;
- an accepted sample or a clear request makes the block busy on the next cycle;
- every delay-memory write stays inside the section range.

Only the bench's scenarios can show the rest. These are the numerical response of the shared section across the chain, the persistence of delay values between samples, saturation at both rails, and the fact that a clear leaves the coefficients intact. The bench compares every cycle against a behavioural model that computes the whole cascade on integers.

// File: rtl/iir_tm_pkg.sv
package iir_tm_pkg;

    localparam int MAX_SECTIONS = 25;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CF_A2 = 2'd0,
        CF_A3 = 2'd1,
        CF_B2 = 2'd2,
        CF_B3 = 2'd3
    } coef_sel_e;

endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank #(
    parameter int NSEC = 4,
    parameter int CW   = 16,
    parameter int SW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SW-1:0]        wsec,
    input  logic [1:0]           wsel,
    input  logic signed [CW-1:0] wdata,
    input  logic [SW-1:0]        rsec,
    output logic signed [CW-1:0] a2,
    output logic signed [CW-1:0] a3,
    output logic signed [CW-1:0] b2,
    output logic signed [CW-1:0] b3
);
    import iir_tm_pkg::*;

    logic signed [CW-1:0] ca2 [NSEC];
    logic signed [CW-1:0] ca3 [NSEC];
    logic signed [CW-1:0] cb2 [NSEC];
    logic signed [CW-1:0] cb3 [NSEC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEC; s++) begin
                ca2[s] <= '0;
                ca3[s] <= '0;
                cb2[s] <= '0;
                cb3[s] <= '0;
            end
        end else if (we) begin
            for (int s = 0; s < NSEC; s++) begin
                if (int'(wsec) == s) begin
                    unique case (coef_sel_e'(wsel))
                        CF_A2: ca2[s] <= wdata;
                        CF_A3: ca3[s] <= wdata;
                        CF_B2: cb2[s] <= wdata;
                        CF_B3: cb3[s] <= wdata;
                    endcase
                end
            end
        end
    end

    assign a2 = ca2[rsec];
    assign a3 = ca3[rsec];
    assign b2 = cb2[rsec];
    assign b3 = cb3[rsec];

endmodule

// File: rtl/iir_state_mem.sv
module iir_state_mem #(
    parameter int NSEC = 4,
    parameter int IW   = 32,
    parameter int SW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 zero,
    input  logic [SW-1:0]        addr,
    input  logic signed [IW-1:0] w1_in,
    input  logic signed [IW-1:0] w2_in,
    output logic signed [IW-1:0] w1_out,
    output logic signed [IW-1:0] w2_out
);
    logic signed [IW-1:0] d1 [NSEC];
    logic signed [IW-1:0] d2 [NSEC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEC; s++) begin
                d1[s] <= '0;
                d2[s] <= '0;
            end
        end else if (we) begin
            for (int s = 0; s < NSEC; s++) begin
                if (int'(addr) == s) begin
                    d1[s] <= zero ? '0 : w1_in;
                    d2[s] <= zero ? '0 : w2_in;
                end
            end
        end
    end

    assign w1_out = d1[addr];
    assign w2_out = d2[addr];

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(addr) < NSEC)); // R4

endmodule

// File: rtl/iir_section_alu.sv
module iir_section_alu #(
    parameter int IW   = 32,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [IW-1:0] x,
    input  logic signed [IW-1:0] w1,
    input  logic signed [IW-1:0] w2,
    input  logic signed [CW-1:0] a2,
    input  logic signed [CW-1:0] a3,
    input  logic signed [CW-1:0] b2,
    input  logic signed [CW-1:0] b3,
    output logic signed [IW-1:0] y,
    output logic signed [IW-1:0] w1_nxt,
    output logic signed [IW-1:0] w2_nxt
);
    localparam int PW = IW + CW;

    logic signed [PW-1:0] p_b2x, p_a2y, p_b3x, p_a3y;
    logic signed [IW-1:0] s_b2x, s_a2y, s_b3x, s_a3y;
    logic                 unused_prod_bits;

    always_comb begin
        y      = x + w1;
        p_b2x  = PW'(b2) * PW'(x);
        p_a2y  = PW'(a2) * PW'(y);
        p_b3x  = PW'(b3) * PW'(x);
        p_a3y  = PW'(a3) * PW'(y);
        s_b2x  = p_b2x[FRAC +: IW];
        s_a2y  = p_a2y[FRAC +: IW];
        s_b3x  = p_b3x[FRAC +: IW];
        s_a3y  = p_a3y[FRAC +: IW];
        w1_nxt = s_b2x - s_a2y + w2;
        w2_nxt = s_b3x - s_a3y;
    end

    assign unused_prod_bits = ^{p_b2x[FRAC-1:0], p_a2y[FRAC-1:0], p_b3x[FRAC-1:0],
                                p_a3y[FRAC-1:0], p_b2x[PW-1:FRAC+IW], p_a2y[PW-1:FRAC+IW],
                                p_b3x[PW-1:FRAC+IW], p_a3y[PW-1:FRAC+IW]};

endmodule

// File: rtl/iir_cascade_tm.sv
module iir_cascade_tm #(
    parameter int NSEC = 4,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int IW   = 32,
    parameter int HEAD = 4,
    parameter int SW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          busy,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_sec,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_data
);
    import iir_tm_pkg::*;

    localparam int XSH = IW - DW - HEAD;
    localparam logic [SW-1:0] LAST = SW'(NSEC - 1);
    localparam logic signed [IW-1:0] OUT_MAX = IW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [IW-1:0] OUT_MIN = -OUT_MAX - 1;

    seq_state_e           state, state_n;
    logic [SW-1:0]        idx;
    logic signed [IW-1:0] sample_r, fb_r;
    logic signed [IW-1:0] x_cur, y_cur, w1_rd, w2_rd, w1_nx, w2_nx, y_sh;
    logic signed [CW-1:0] c_a2, c_a3, c_b2, c_b3;
    logic                 at_last, accept, mem_we, mem_zero, finish;
    logic [DW-1:0]        y_sat;

    assign at_last  = (idx == LAST);
    assign in_ready = (state == ST_IDLE) && !clr;
    assign accept   = in_ready && in_valid;
    assign busy     = (state != ST_IDLE);
    assign x_cur    = (idx == '0) ? sample_r : fb_r;
    assign mem_we   = ((state == ST_RUN) && !clr) || (state == ST_CLEAR);
    assign mem_zero = (state == ST_CLEAR);
    assign finish   = (state == ST_RUN) && !clr && at_last;

    iir_coef_bank #(.NSEC(NSEC), .CW(CW), .SW(SW)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsec(cfg_sec), .wsel(cfg_sel),
        .wdata(cfg_data), .rsec(idx), .a2(c_a2), .a3(c_a3), .b2(c_b2), .b3(c_b3));

    iir_state_mem #(.NSEC(NSEC), .IW(IW), .SW(SW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .zero(mem_zero), .addr(idx),
        .w1_in(w1_nx), .w2_in(w2_nx), .w1_out(w1_rd), .w2_out(w2_rd));

    iir_section_alu #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_alu (
        .x(x_cur), .w1(w1_rd), .w2(w2_rd), .a2(c_a2), .a3(c_a3), .b2(c_b2), .b3(c_b3),
        .y(y_cur), .w1_nxt(w1_nx), .w2_nxt(w2_nx));

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (clr) state_n = ST_CLEAR;
                      else if (in_valid) state_n = ST_RUN;
            ST_RUN:   if (clr) state_n = ST_CLEAR;
                      else if (at_last) state_n = ST_IDLE;
            ST_CLEAR: if (at_last && !clr) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register, section index and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            sample_r <= '0;
            fb_r     <= '0;
        end else begin
            state <= state_n;
            if (state_n != state || at_last) idx <= '0;
            else if (state != ST_IDLE)       idx <= idx + SW'(1);
            if (accept)
                sample_r <= {{HEAD{in_data[DW-1]}}, in_data, {XSH{1'b0}}};
            if (state == ST_RUN)
                fb_r <= y_cur;
        end
    end

    // output saturation and result register
    always_comb begin
        y_sh = y_cur >>> XSH;
        if (y_sh > OUT_MAX)      y_sat = OUT_MAX[DW-1:0];
        else if (y_sh < OUT_MIN) y_sat = OUT_MIN[DW-1:0];
        else                     y_sat = y_sh[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= finish;
            if (finish) out_data <= y_sat;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5
    AST_STROBE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy)); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy); // R6
    AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (busy && !out_valid)); // R8

endmodule

// File: tb/iir_cascade_tm_test.sv
`timescale 1ns/1ps
module iir_cascade_tm_test;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, busy;
    logic [15:0] out_data;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sec = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string ph = "R1 reset";

    always #2.5 clk = ~clk;

    iir_cascade_tm #(.NSEC(N)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .busy(busy),
        .cfg_we(cfg_we), .cfg_sec(cfg_sec), .cfg_sel(cfg_sel), .cfg_data(cfg_data));

    // ---------------- behavioural reference ----------------
    longint ma2[N], ma3[N], mb2[N], mb3[N], mw1[N], mw2[N];
    int     mode = 0;  // 0 idle, 1 running, 2 clearing
    int     cnt = 0;
    longint pend = 0;
    longint exp_data = 0;
    bit     exp_valid = 0;

    function automatic longint wrap32(longint v);
        return longint'(int'(v));
    endfunction

    function automatic longint scl(longint c, longint v);
        return wrap32((c * v) >>> 14);
    endfunction

    function automatic longint cascade(logic [15:0] din);
        longint x, y, n1, n2, o;
        x = wrap32(longint'($signed(din)) * 4096);
        y = 0;
        for (int k = 0; k < N; k++) begin
            y  = wrap32(x + mw1[k]);
            n1 = wrap32(scl(mb2[k], x) - scl(ma2[k], y) + mw2[k]);
            n2 = wrap32(scl(mb3[k], x) - scl(ma3[k], y));
            mw1[k] = n1;
            mw2[k] = n2;
            x = y;
        end
        o = y >>> 12;
        if (o > 32767) o = 32767;
        if (o < -32768) o = -32768;
        return o;
    endfunction

    task automatic mzero();
        for (int k = 0; k < N; k++) begin
            mw1[k] = 0;
            mw2[k] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; cnt = 0; exp_valid = 0; exp_data = 0;
            mzero();
            for (int k = 0; k < N; k++) begin
                ma2[k] = 0; ma3[k] = 0; mb2[k] = 0; mb3[k] = 0;
            end
        end else begin
            exp_valid = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: ma2[cfg_sec] = longint'($signed(cfg_data));
                    2'd1: ma3[cfg_sec] = longint'($signed(cfg_data));
                    2'd2: mb2[cfg_sec] = longint'($signed(cfg_data));
                    default: mb3[cfg_sec] = longint'($signed(cfg_data));
                endcase
            end
            case (mode)
                0: if (clr) begin mode = 2; cnt = 0; mzero(); end
                   else if (in_valid) begin pend = cascade(in_data); mode = 1; cnt = 0; end
                1: if (clr) begin mode = 2; cnt = 0; mzero(); end
                   else if (cnt == N - 1) begin exp_valid = 1; exp_data = pend; mode = 0; end
                   else cnt++;
                default: if (cnt == N - 1) begin if (clr) cnt = 0; else mode = 0; end
                         else cnt++;
            endcase
        end
    end

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(in_ready == (mode == 0 && !clr), "R6 in_ready", in_ready, (mode == 0 && !clr));
            chk(busy == (mode != 0), "R8 busy", busy, (mode != 0));
            chk(out_valid == exp_valid, "R5 out_valid", out_valid, exp_valid);
            chk(longint'($signed(out_data)) == exp_data, ph, $signed(out_data), exp_data);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wcoef(int sec, int sel, int val);
        cfg_we = 1; cfg_sec = 2'(sec); cfg_sel = 2'(sel); cfg_data = 16'(val);
        tick();
        cfg_we = 0;
    endtask

    task automatic send(int val);
        while (!in_ready) tick();
        in_valid = 1; in_data = 16'(val);
        tick();
        in_valid = 0;
        while (busy) tick();
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1 && busy == 0, "R1 ready/busy in reset", {in_ready, busy}, 2'b10);
        chk(out_valid == 0 && out_data == 0, "R1 outputs in reset", out_data, 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1 && busy == 0 && out_valid == 0, "R1 after release",
            {in_ready, busy, out_valid}, 3'b100);

        ph = "R7 passthrough with reset coefficients (R1)";
        send(1234); send(-3000); send(32767); send(-32768);

        ph = "R7 saturation via R2 coefficient b2=1.0";
        wcoef(0, 2, 16384);
        send(30000); send(30000); send(-30000); send(-30000); send(100);
        wcoef(0, 2, 0);

        ph = "R3 R4 impulse through all sections";
        for (int k = 0; k < N; k++) begin
            wcoef(k, 0, -6000 + 1500 * k);
            wcoef(k, 1, 2000);
            wcoef(k, 2, 9000 - 1000 * k);
            wcoef(k, 3, 3000);
        end
        clr = 1; tick(); clr = 0;
        while (busy) tick();
        send(8000);
        ph = "R10 decay tail from stored delays";
        for (int i = 0; i < 10; i++) send(0);

        ph = "R3 mixed samples";
        for (int i = 0; i < 30; i++) send($signed(16'($urandom_range(0, 16000))) - 8000);

        ph = "R6 in_valid held during busy";
        in_valid = 1;
        for (int i = 0; i < 40; i++) begin
            in_data = 16'(i * 311 - 6000);
            tick();
        end
        in_valid = 0;
        while (busy) tick();

        ph = "R8 clear mid-run drops sample";
        while (!in_ready) tick();
        in_valid = 1; in_data = 16'(5000); tick(); in_valid = 0;
        tick(); tick();
        clr = 1; tick(); clr = 0;
        while (busy) tick();
        ph = "R9 fresh response after clear";
        send(8000);
        send(0);

        ph = "R8 long clear restarts sweep";
        clr = 1;
        repeat (2 * N + 3) tick();
        clr = 0;
        while (busy) tick();
        ph = "R9 fresh response after long clear";
        send(8000);

        ph = "R8 clear from idle";
        clr = 1; tick(); clr = 0;
        while (busy) tick();
        send(-7000); send(1200);

        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule